// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a south-bridge style Super I/O function. The host uses two I/O locations. It writes a register number to the first location. It then reads or writes that register through the second location. Behind the pair sits a file of 256 byte-wide registers.

Some index ranges are read-only, and writes to them are dropped. Two indices apply a write mask before storing. The other writable indices keep the byte exactly as written, and each such write raises a one-cycle notice that the register has no hardware function.

Two of the stored registers drive a live serial-port decoder. One bit of the function-select register turns the decode on. A second register places the serial port's 8-byte window anywhere on an 8-byte boundary in a 10-bit I/O space. The decoder compares host I/O addresses against that window and drives a chip-select and a 3-bit register offset to the UART.

Top module: `sio_cfg_port`

## Requirements
- R1: A write with `cfg_addr`=0 loads the index register at the next clock edge. A read with `cfg_addr`=0 returns the current index.
- R2: A read with `cfg_addr`=1 returns the register selected by the current index. A write with `cfg_addr`=1 updates that register at the next clock edge, subject to R3 to R5 and R9.
- R3: Data-port writes are dropped, leaving the stored byte unchanged and raising no notice, when the index lies in 0x00-0xDF, 0xE7-0xEF, 0xF0, 0xF1, 0xF5, 0xF8 or 0xFD.
- R4: A data-port write to index 0xF2 (function select) stores the written byte ANDed with 0x17.
- R5: A data-port write to index 0xF4 stores the written byte ANDed with 0xFE. The serial window base is that stored value shifted left by two bit positions.
- R6: `ser_cs` is high exactly when bit 2 of register 0xF2 is set and `io_addr[9:3]` equals the base bits [9:3]. `ser_offs` equals `io_addr[2:0]`.
- R7: Once bit 2 of register 0xF2 is cleared, no I/O address asserts `ser_cs`.
- R8: Rewriting 0xF4 while decode is enabled moves the window from the next clock edge onward. The old base stops matching and the new base matches.
- R9: A data-port write to any writable index other than 0xF2 and 0xF4 stores the byte unmodified. It also drives `unimp_pulse` high for exactly the one cycle after the write edge.
- R10: After reset, the index and every register read as zero and `ser_cs` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronized inside the block. |
| cfg_wr | input | 1 | Write strobe for the configuration pair, one cycle per write |
| cfg_addr | input | 1 | 0 selects the index location, 1 selects the data location |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the location selected by `cfg_addr` (combinational) |
| io_addr | input | 10 | Host I/O address checked by the serial decoder |
| ser_cs | output | 1 | Serial-port chip-select |
| ser_offs | output | 3 | Register offset passed to the UART |
| unimp_pulse | output | 1 | One-cycle notice of a write to a register with no hardware function |

## Verification
The bench builds the block with its default parameters: a 10-bit I/O space, a base shift of two and an 8-byte window. With these values the window fits exactly on 8-byte boundaries, so both a high base (0x3F8) and a lower one (0x2F8) can be reached. Addresses are probed just inside and just outside each window. Read-only indices are sampled from every excluded range, and writable indices from both the low unused group and the high one, so the masks, the dropped writes and the notice pulse are each observed on their own data-port readback.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 8;
  localparam int NREG   = 1 << IDX_W;

  localparam logic [IDX_W-1:0]  FUNC_IDX  = 8'hF2;
  localparam logic [IDX_W-1:0]  BASE_IDX  = 8'hF4;
  localparam logic [DATA_W-1:0] FUNC_MASK = 8'h17;
  localparam logic [DATA_W-1:0] BASE_MASK = 8'hFE;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] byte_t;

  // Indices whose data-port writes are discarded
  function automatic logic idx_locked(input idx_t idx);
    return idx inside {[8'h00:8'hDF], [8'hE7:8'hEF], 8'hF0, 8'hF1,
                       8'hF5, 8'hF8, 8'hFD};
  endfunction

  // Writable indices with no hardware function behind them
  function automatic logic idx_spare(input idx_t idx);
    return !idx_locked(idx) && (idx != FUNC_IDX) && (idx != BASE_IDX);
  endfunction

  function automatic byte_t store_mask(input idx_t idx);
    if (idx == FUNC_IDX)      return FUNC_MASK;
    else if (idx == BASE_IDX) return BASE_MASK;
    else                      return '1;
  endfunction
endpackage

// File: rtl/sio_cfg_index.sv
module sio_cfg_index
  import sio_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idx_we,
  input  byte_t idx_wdata,
  output idx_t  idx_q
);
  idx_t idx_d;

  always_comb begin
    idx_d = idx_q;
    if (idx_we) idx_d = idx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idx_we) |-> idx_q == $past(idx_wdata));
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dat_we,
  input  idx_t  idx,
  input  byte_t dat_wdata,
  output byte_t dat_rdata,
  output byte_t func_q,
  output byte_t base_q,
  output logic  unimp_q
);
  logic [NREG-1:0][DATA_W-1:0] regs_q, regs_d;
  logic unimp_d;
  logic store_en;

  assign store_en = dat_we && !idx_locked(idx);

  always_comb begin
    regs_d  = regs_q;
    unimp_d = 1'b0;
    if (store_en) begin
      regs_d[idx] = dat_wdata & store_mask(idx);
      unimp_d     = idx_spare(idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q  <= '0;
      unimp_q <= 1'b0;
    end else begin
      regs_q  <= regs_d;
      unimp_q <= unimp_d;
    end
  end

  assign dat_rdata = regs_q[idx];
  assign func_q    = regs_q[FUNC_IDX];
  assign base_q    = regs_q[BASE_IDX];

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx_locked(idx)) |=> $stable(regs_q));
  assert_func_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx == FUNC_IDX) |=> func_q == ($past(dat_wdata) & FUNC_MASK));
  assert_base_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx == BASE_IDX) |=> base_q == ($past(dat_wdata) & BASE_MASK));
  assert_unimp_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unimp_q |-> ($past(dat_we) && idx_spare($past(idx))));
endmodule

// File: rtl/sio_serial_decode.sv
module sio_serial_decode
  import sio_cfg_pkg::*;
#(
  parameter int IO_AW      = 10,
  parameter int BASE_SHIFT = 2,
  parameter int EN_BIT     = 2,
  parameter int WIN_BITS   = BASE_SHIFT + 1
) (
  input  byte_t             func_q,
  input  byte_t             base_q,
  input  logic [IO_AW-1:0]  io_addr,
  output logic              dec_en,
  output logic              ser_cs,
  output logic [WIN_BITS-1:0] ser_offs
);
  localparam int BASE_W = DATA_W + BASE_SHIFT;

  logic [BASE_W-1:0] base_full;
  logic              hit;

  assign base_full = {base_q, {BASE_SHIFT{1'b0}}};
  assign dec_en    = func_q[EN_BIT];

  generate
    if (IO_AW <= BASE_W) begin : g_cmp_fit
      assign hit = io_addr[IO_AW-1:WIN_BITS] == base_full[IO_AW-1:WIN_BITS];
    end else begin : g_cmp_wide
      assign hit = (io_addr[IO_AW-1:BASE_W] == '0) &&
                   (io_addr[BASE_W-1:WIN_BITS] == base_full[BASE_W-1:WIN_BITS]);
    end
  endgenerate

  assign ser_cs   = dec_en && hit;
  assign ser_offs = io_addr[WIN_BITS-1:0];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int IO_AW      = 10,
  parameter int BASE_SHIFT = 2,
  parameter int EN_BIT     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic [IO_AW-1:0] io_addr,
  output logic             ser_cs,
  output logic [BASE_SHIFT:0] ser_offs,
  output logic             unimp_pulse
);
  localparam int WIN_BITS = BASE_SHIFT + 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  idx_t       idx_q;
  byte_t      dat_rdata, func_q, base_q;
  logic       dec_en;
  logic       idx_we, dat_we;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign idx_we = cfg_wr && !cfg_addr;
  assign dat_we = cfg_wr &&  cfg_addr;

  sio_cfg_index u_index (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .idx_we    (idx_we),
    .idx_wdata (cfg_wdata),
    .idx_q     (idx_q)
  );

  sio_cfg_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .dat_we    (dat_we),
    .idx       (idx_q),
    .dat_wdata (cfg_wdata),
    .dat_rdata (dat_rdata),
    .func_q    (func_q),
    .base_q    (base_q),
    .unimp_q   (unimp_pulse)
  );

  sio_serial_decode #(
    .IO_AW      (IO_AW),
    .BASE_SHIFT (BASE_SHIFT),
    .EN_BIT     (EN_BIT),
    .WIN_BITS   (WIN_BITS)
  ) u_dec (
    .func_q   (func_q),
    .base_q   (base_q),
    .io_addr  (io_addr),
    .dec_en   (dec_en),
    .ser_cs   (ser_cs),
    .ser_offs (ser_offs)
  );

  assign cfg_rdata = cfg_addr ? dat_rdata : idx_q;

  assert_cs_gated_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dec_en |-> !ser_cs);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_int_n |-> (!ser_cs && !unimp_pulse));
  assert_relocate_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dat_we && idx_q == BASE_IDX && dec_en) |=> $stable(dec_en));
endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_CS = 1, K_UN = 2;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_addr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [9:0] io_addr;
  logic       ser_cs, unimp_pulse;
  logic [2:0] ser_offs;
  logic       probe;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .ser_cs(ser_cs), .ser_offs(ser_offs), .unimp_pulse(unimp_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: pops one expected item per probed cycle
  always @(negedge clk) begin
    if (probe && q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = {8'h00, cfg_rdata};
        K_CS:    act = {12'h000, ser_cs, ser_offs};
        default: act = {15'h0000, unimp_pulse};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push_probe(input int kind, input logic [15:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    probe = 1'b1;
    tick();
    probe = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  // Data write, then check the notice pulse in the cycle after the edge
  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d,
                           input logic exp_un, input string tag);
    wr(1'b0, idx);
    wr(1'b1, d);
    push_probe(K_UN, {15'h0, exp_un}, tag);
  endtask

  task automatic reg_read(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    wr(1'b0, idx);
    cfg_addr = 1'b1;
    push_probe(K_RD, {8'h00, exp}, tag);
  endtask

  task automatic cs_check(input logic [9:0] a, input logic exp_cs, input string tag);
    io_addr = a;
    push_probe(K_CS, {12'h0, exp_cs, a[2:0]}, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    io_addr = '0; probe = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R10 reset state
    cfg_addr = 1'b0;
    push_probe(K_RD, 16'h0000, "R10 index after reset");
    cfg_addr = 1'b1;
    push_probe(K_RD, 16'h0000, "R10 reg 00 after reset");
    reg_read(8'hF2, 8'h00, "R10 func select after reset");
    cs_check(10'h000, 1'b0, "R10 decode off after reset");

    // R1 index write and readback
    wr(1'b0, 8'h5A);
    cfg_addr = 1'b0;
    push_probe(K_RD, 16'h005A, "R1 index readback");

    // R9 spare writable indices, R2 readback
    reg_write(8'hE3, 8'hA5, 1'b1, "R9 pulse on E3");
    push_probe(K_UN, 16'h0000, "R9 pulse one cycle wide");
    reg_read(8'hE3, 8'hA5, "R2 R9 E3 unmodified");
    reg_write(8'hFF, 8'h3C, 1'b1, "R9 pulse on FF");
    reg_read(8'hFF, 8'h3C, "R2 R9 FF unmodified");
    reg_write(8'hF3, 8'hC3, 1'b1, "R9 pulse on F3");
    reg_read(8'hF3, 8'hC3, "R2 R9 F3 unmodified");

    // R3 locked indices
    reg_write(8'h10, 8'hFF, 1'b0, "R3 no pulse on 10");
    reg_read(8'h10, 8'h00, "R3 reg 10 unchanged");
    reg_write(8'hDF, 8'h77, 1'b0, "R3 no pulse on DF");
    reg_read(8'hDF, 8'h00, "R3 reg DF unchanged");
    reg_write(8'hE7, 8'h11, 1'b0, "R3 no pulse on E7");
    reg_read(8'hE7, 8'h00, "R3 reg E7 unchanged");
    reg_write(8'hF1, 8'h22, 1'b0, "R3 no pulse on F1");
    reg_read(8'hF1, 8'h00, "R3 reg F1 unchanged");
    reg_write(8'hF5, 8'h33, 1'b0, "R3 no pulse on F5");
    reg_read(8'hF5, 8'h00, "R3 reg F5 unchanged");
    reg_write(8'hF8, 8'h44, 1'b0, "R3 no pulse on F8");
    reg_read(8'hF8, 8'h00, "R3 reg F8 unchanged");
    reg_write(8'hFD, 8'h55, 1'b0, "R3 no pulse on FD");
    reg_read(8'hFD, 8'h00, "R3 reg FD unchanged");

    // R4 / R5 masks
    reg_write(8'hF4, 8'hFF, 1'b0, "R5 no pulse on base write");
    reg_read(8'hF4, 8'hFE, "R5 base mask");
    cs_check(10'h3F9, 1'b0, "R7 decode off before enable");
    reg_write(8'hF2, 8'hFF, 1'b0, "R4 no pulse on func write");
    reg_read(8'hF2, 8'h17, "R4 func mask");

    // R6 decode window at 0x3F8
    cs_check(10'h3F8, 1'b1, "R6 base low edge");
    cs_check(10'h3FB, 1'b1, "R6 inside window");
    cs_check(10'h3FF, 1'b1, "R6 base high edge");
    cs_check(10'h3F7, 1'b0, "R6 below window");
    cs_check(10'h2F8, 1'b0, "R6 other window");

    // R8 relocation while enabled
    reg_write(8'hF4, 8'hBE, 1'b0, "R8 no pulse on relocate");
    cs_check(10'h2F9, 1'b1, "R8 new base hit");
    cs_check(10'h3F9, 1'b0, "R8 old base miss");
    cs_check(10'h300, 1'b0, "R8 above new window");

    // R7 disable via bit 2
    reg_write(8'hF2, 8'h13, 1'b0, "R7 no pulse on func write");
    reg_read(8'hF2, 8'h13, "R7 func readback");
    cs_check(10'h2F9, 1'b0, "R7 decode off at base");
    cs_check(10'h2FE, 1'b0, "R7 decode off in window");

    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule